// File: doc/BRIEF.md
# VOQ crossbar cell switch

An eight-port cell switch for a fabric card. Every ingress port receives fixed-size cells as a stream of 16-bit beats. The first beat carries a start flag and the number of the destination port. Each arriving cell is stored in a queue that belongs to its input and destination pair, so a congested output never holds up an input's traffic to other outputs.

Once every four-cycle cell slot, a round-robin matcher pairs inputs with outputs. Matched cells move through a crossbar, one beat per cycle, into a queue behind each output. Each egress port drains its own queue through a ready/valid handshake, and this handshake is the fabric's flow control. When an output queue cannot take a whole cell, no cell is sent to it. Cells then collect in the ingress queues. When such a queue is full, the ingress port refuses new cells for that destination, and no cell is ever dropped.

Port counts, beat width, cell length and queue depths are parameters. The port count, the cell length and both queue depths must be powers of two, because pointers wrap naturally.

Top module: `voq_switch`

## Requirements
- R1: While reset is asserted and right after it is released, every out_valid is low and every in_ready is high.
- R2: A cell is 4 beats. The first beat has in_sop high, and bits [2:0] of that beat name the destination output. The cell leaves that output with all 4 beats unchanged, out_sop high on its first beat only.
- R3: When an input has no cell in progress, a beat with in_sop low is accepted (in_ready high) and discarded. It produces no output.
- R4: Each input holds up to 8 cells per destination. A first beat whose destination queue already holds 8 cells sees in_ready low until space frees. Once a first beat is accepted, the remaining beats of that cell are never refused.
- R5: A full queue for one destination does not stop the same input from sending cells to other destinations.
- R6: Each output queue holds up to 32 cells. No cell enters a full output queue. Cells held back wait at ingress and are all delivered once the output drains.
- R7: Each output keeps a round-robin pointer. After a grant to input k, the next search for that output starts at input k+1 and wraps. The pointer moves only when a grant is made.
- R8: In each 4-cycle slot, an output receives at most one cell and an input sends at most one cell. Traffic without conflicts moves in parallel, one cell per slot on every output.
- R9: An output beat is taken on a clock edge where out_valid and out_ready are both high. While out_valid is high and out_ready is low, out_valid, out_sop and out_data hold.
- R10: Cells from one input to one output leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 8 | Per input: a beat is offered |
| in_sop | input | 8 | Per input: the offered beat starts a cell |
| in_data | input | 128 | Per input 16-bit beat, input p in bits [16p+15:16p] |
| in_ready | output | 8 | Per input: the offered beat is taken at this edge |
| out_valid | output | 8 | Per output: a beat is offered |
| out_sop | output | 8 | Per output: the offered beat starts a cell |
| out_data | output | 128 | Per output 16-bit beat, output p in bits [16p+15:16p] |
| out_ready | input | 8 | Per output: the sink takes the offered beat |

## Verification
Every cell carries its source, destination and sequence number, so a wrong state shows up at the port within one cell. A bad queue pointer, a lost count update, or a crossbar beat landing on the wrong output appears as a corrupt, reordered or misrouted cell. A wrong full count shows up either as a stall that never clears or as in_ready staying high past the eighth queued cell. A misplaced round-robin pointer changes the order in which contending inputs appear at the shared output, starting with the very next contended slot.

// File: rtl/voq_switch.sv
module voq_switch #(
  parameter int NP    = 8,
  parameter int W     = 16,
  parameter int BEATS = 4,
  parameter int VQD   = 8,
  parameter int OQD   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP-1:0]   in_valid,
  input  logic [NP-1:0]   in_sop,
  input  logic [NP*W-1:0] in_data,
  output logic [NP-1:0]   in_ready,
  output logic [NP-1:0]   out_valid,
  output logic [NP-1:0]   out_sop,
  output logic [NP*W-1:0] out_data,
  input  logic [NP-1:0]   out_ready
);
  localparam int PW  = $clog2(NP);
  localparam int BW  = $clog2(BEATS);
  localparam int VAW = $clog2(VQD);
  localparam int OAW = $clog2(OQD);
  localparam int VCW = VAW + 1;
  localparam int OCW = OAW + 1;

  logic [W-1:0] voq_mem [NP][NP][VQD][BEATS];
  logic [W-1:0] oq_mem  [NP][OQD][BEATS];

  logic [NP-1:0][NP-1:0][VCW-1:0] voq_cnt;
  logic [NP-1:0][NP-1:0][VAW-1:0] voq_wp, voq_rp;
  logic [NP-1:0][NP-1:0]          voq_inc, voq_dec;
  logic [NP-1:0][OCW-1:0]         oq_cnt;
  logic [NP-1:0][OAW-1:0]         oq_wp, oq_rp;
  logic [NP-1:0]                  oq_inc, oq_dec;
  logic [NP-1:0][BW-1:0]          ob_beat;

  logic [NP-1:0]         ib_busy, wr_en, wr_last;
  logic [NP-1:0][BW-1:0] ib_beat, wbeat;
  logic [NP-1:0][PW-1:0] ib_dst, wr_dst;

  logic [BW-1:0]         phase;
  logic                  slot_start, xfer_end;
  logic [NP-1:0][PW-1:0] rr_ptr, g_src, sel_src, act_src;
  logic [NP-1:0]         g_v, sel_v, act_v, taken;
  logic [NP-1:0][NP-1:0] gnt_m;
  logic [PW-1:0]         cand;
  logic [NP-1:0][W-1:0]  xb_data;

  assign slot_start = phase == '0;
  assign xfer_end   = phase == BW'(BEATS - 1);

  // ingress framing
  always_comb
    for (int i = 0; i < NP; i++) begin
      wr_dst[i]   = ib_busy[i] ? ib_dst[i] : in_data[i*W +: PW];
      wbeat[i]    = ib_busy[i] ? ib_beat[i] : '0;
      in_ready[i] = ib_busy[i] | ~in_sop[i] | (voq_cnt[i][wr_dst[i]] < VCW'(VQD));
      wr_en[i]    = in_valid[i] & in_ready[i] & (ib_busy[i] | in_sop[i]);
      wr_last[i]  = wr_en[i] & ib_busy[i] & (ib_beat[i] == BW'(BEATS - 1));
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ib_busy <= '0;
      ib_beat <= '0;
      ib_dst  <= '0;
    end else
      for (int i = 0; i < NP; i++)
        if (wr_en[i]) begin
          if (!ib_busy[i]) begin
            ib_busy[i] <= 1'b1;
            ib_beat[i] <= BW'(1);
            ib_dst[i]  <= wr_dst[i];
          end else if (wr_last[i]) begin
            ib_busy[i] <= 1'b0;
            ib_beat[i] <= '0;
          end else
            ib_beat[i] <= ib_beat[i] + 1'b1;
        end

  always_ff @(posedge clk)
    for (int i = 0; i < NP; i++)
      if (wr_en[i])
        voq_mem[i][wr_dst[i]][voq_wp[i][wr_dst[i]]][wbeat[i]] <= in_data[i*W +: W];

  // round-robin matcher, one pass over the outputs
  always_comb begin
    taken = '0;
    gnt_m = '0;
    cand  = '0;
    for (int o = 0; o < NP; o++) begin
      g_v[o]   = 1'b0;
      g_src[o] = '0;
      for (int k = 0; k < NP; k++) begin
        cand = rr_ptr[o] + PW'(k);
        if (!g_v[o] && !taken[cand] && voq_cnt[cand][o] != '0 && oq_cnt[o] < OCW'(OQD)) begin
          g_v[o]   = 1'b1;
          g_src[o] = cand;
        end
      end
      if (g_v[o]) begin
        taken[g_src[o]]    = 1'b1;
        gnt_m[o][g_src[o]] = 1'b1;
      end
    end
  end

  // crossbar
  always_comb
    for (int o = 0; o < NP; o++) begin
      act_v[o]   = slot_start ? g_v[o] : sel_v[o];
      act_src[o] = slot_start ? g_src[o] : sel_src[o];
      xb_data[o] = voq_mem[act_src[o]][o][voq_rp[act_src[o]][o]][phase];
    end

  always_ff @(posedge clk)
    for (int o = 0; o < NP; o++)
      if (act_v[o]) oq_mem[o][oq_wp[o]][phase] <= xb_data[o];

  always_comb
    for (int i = 0; i < NP; i++)
      for (int d = 0; d < NP; d++) begin
        voq_inc[i][d] = wr_last[i] && ib_dst[i] == PW'(d);
        voq_dec[i][d] = xfer_end && act_v[d] && act_src[d] == PW'(i);
      end

  always_comb
    for (int o = 0; o < NP; o++) begin
      oq_inc[o] = xfer_end && act_v[o];
      oq_dec[o] = out_valid[o] && out_ready[o] && ob_beat[o] == BW'(BEATS - 1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= '0;
      rr_ptr  <= '0;
      sel_v   <= '0;
      sel_src <= '0;
      voq_cnt <= '0;
      voq_wp  <= '0;
      voq_rp  <= '0;
      oq_cnt  <= '0;
      oq_wp   <= '0;
      oq_rp   <= '0;
      ob_beat <= '0;
    end else begin
      phase <= xfer_end ? '0 : phase + 1'b1;
      if (slot_start) begin
        sel_v   <= g_v;
        sel_src <= g_src;
        for (int o = 0; o < NP; o++)
          if (g_v[o]) rr_ptr[o] <= g_src[o] + 1'b1;
      end
      for (int i = 0; i < NP; i++)
        for (int d = 0; d < NP; d++) begin
          voq_cnt[i][d] <= voq_cnt[i][d] + VCW'(voq_inc[i][d]) - VCW'(voq_dec[i][d]);
          voq_wp[i][d]  <= voq_wp[i][d] + VAW'(voq_inc[i][d]);
          voq_rp[i][d]  <= voq_rp[i][d] + VAW'(voq_dec[i][d]);
        end
      for (int o = 0; o < NP; o++) begin
        oq_cnt[o] <= oq_cnt[o] + OCW'(oq_inc[o]) - OCW'(oq_dec[o]);
        oq_wp[o]  <= oq_wp[o] + OAW'(oq_inc[o]);
        oq_rp[o]  <= oq_rp[o] + OAW'(oq_dec[o]);
        if (out_valid[o] && out_ready[o])
          ob_beat[o] <= oq_dec[o] ? '0 : ob_beat[o] + 1'b1;
      end
    end

  // egress
  always_comb
    for (int o = 0; o < NP; o++) begin
      out_valid[o]        = oq_cnt[o] != '0;
      out_sop[o]          = ob_beat[o] == '0;
      out_data[o*W +: W]  = oq_mem[o][oq_rp[o]][ob_beat[o]];
    end

endmodule

// File: rtl/voq_switch_chk.sv
module voq_switch_chk #(
  parameter int NP  = 8,
  parameter int W   = 16,
  parameter int VQD = 8,
  parameter int OQD = 32,
  parameter int VCW = 4,
  parameter int OCW = 6
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          slot_start,
  input logic [NP-1:0][NP-1:0]         gnt_m,
  input logic [NP-1:0][NP-1:0][VCW-1:0] voq_cnt,
  input logic [NP-1:0][OCW-1:0]        oq_cnt,
  input logic [NP-1:0]                 out_valid,
  input logic [NP-1:0]                 out_ready,
  input logic [NP-1:0]                 out_sop,
  input logic [NP*W-1:0]               out_data
);
  for (genvar o = 0; o < NP; o++) begin : g_out
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_data[o*W +: W]) && $stable(out_sop[o])); // R9
    AST_ONE_SRC_PER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start |-> $onehot0(gnt_m[o])); // R8
    AST_OQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      oq_cnt[o] <= OCW'(OQD)); // R6
  end

  for (genvar i = 0; i < NP; i++) begin : g_in
    logic [NP-1:0] col;
    for (genvar o = 0; o < NP; o++) begin : g_col
      assign col[o] = gnt_m[o][i];
    end
    AST_ONE_DST_PER_IN: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start |-> $onehot0(col)); // R8
    for (genvar d = 0; d < NP; d++) begin : g_dst
      AST_VOQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        voq_cnt[i][d] <= VCW'(VQD)); // R4
    end
  end
endmodule

bind voq_switch voq_switch_chk #(
  .NP(NP), .W(W), .VQD(VQD), .OQD(OQD), .VCW(VCW), .OCW(OCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .gnt_m(gnt_m),
  .voq_cnt(voq_cnt), .oq_cnt(oq_cnt), .out_valid(out_valid),
  .out_ready(out_ready), .out_sop(out_sop), .out_data(out_data)
);

// File: tb/voq_switch_tb.sv
module voq_switch_tb;
  localparam int NP = 8, W = 16, BEATS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] in_valid = '0, in_sop = '0, out_ready = '0;
  logic [NP*W-1:0] in_data = '0;
  wire  [NP-1:0] in_ready, out_valid, out_sop;
  wire  [NP*W-1:0] out_data;

  always #5 clk = ~clk;

  voq_switch u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_sop(out_sop), .out_data(out_data), .out_ready(out_ready)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  int tx_seq [NP][NP];
  int exp_seq[NP][NP];
  int rx_cnt [NP];
  int tx_total = 0, rx_total = 0;
  int ord_log[512];
  int ord_n = 0;
  logic [W-1:0] rx_buf[NP][BEATS];
  int rx_beat[NP];
  bit rx_bad[NP];
  bit stall_on = 0;
  logic [15:0] lfsr_o = 16'hACE1, lfsr_t = 16'h1D2B;
  int m_s;
  bit m_ok;

  always @(posedge clk) cyc++;

  function automatic logic [15:0] cell_word(int s, int d, int q, int b);
    logic [31:0] v;
    if (b == 0) return {q[9:0], s[2:0], d[2:0]};
    v = q * 37 + s * 11 + d * 5 + b * 4099;
    return v[15:0] ^ 16'hA5C3;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // egress monitor: R2 framing/routing, R10 ordering
  always @(negedge clk)
    if (rst_n)
      for (int o = 0; o < NP; o++)
        if (out_valid[o] && out_ready[o]) begin
          rx_buf[o][rx_beat[o]] = out_data[o*W +: W];
          if (out_sop[o] != (rx_beat[o] == 0)) rx_bad[o] = 1;
          if (rx_beat[o] == BEATS - 1) begin
            m_s  = int'(rx_buf[o][0][5:3]);
            m_ok = !rx_bad[o] && rx_buf[o][0][2:0] == 3'(o);
            for (int b = 0; b < BEATS; b++)
              if (rx_buf[o][b] != cell_word(m_s, o, exp_seq[m_s][o], b)) m_ok = 0;
            check(m_ok, "R2/R10 cell content, route and order", rx_buf[o][0],
                  cell_word(m_s, o, exp_seq[m_s][o], 0));
            exp_seq[m_s][o]++;
            rx_cnt[o]++;
            rx_total++;
            if (o == 0) begin ord_log[ord_n] = m_s; ord_n++; end
            rx_bad[o]  = 0;
            rx_beat[o] = 0;
          end else
            rx_beat[o]++;
        end

  always @(posedge clk)
    if (stall_on) begin
      #1;
      out_ready = lfsr_o[7:0] | lfsr_o[15:8];
      lfsr_o = {lfsr_o[14:0], lfsr_o[15] ^ lfsr_o[13] ^ lfsr_o[12] ^ lfsr_o[10]};
    end

  task automatic send_multi(input logic [NP-1:0] mask, input int dst[NP]);
    int beat[NP];
    logic [NP-1:0] done, acc;
    int n = 0;
    done = ~mask;
    for (int i = 0; i < NP; i++) beat[i] = 0;
    while (done != '1 && n < 3000) begin
      @(negedge clk);
      for (int i = 0; i < NP; i++)
        if (!done[i]) begin
          in_valid[i] = 1'b1;
          in_sop[i]   = beat[i] == 0;
          in_data[i*W +: W] = cell_word(i, dst[i], tx_seq[i][dst[i]], beat[i]);
        end
      #1;
      acc = in_valid & in_ready & ~done;
      @(posedge clk);
      #1;
      n++;
      for (int i = 0; i < NP; i++)
        if (acc[i]) begin
          beat[i]++;
          if (beat[i] == BEATS) begin
            done[i] = 1'b1;
            in_valid[i] = 1'b0;
            in_sop[i] = 1'b0;
            tx_seq[i][dst[i]]++;
            tx_total++;
          end
        end
    end
    if (done != '1) begin
      check(0, "R4 cell refused mid-way or never accepted", done, '1);
      in_valid = '0;
      in_sop = '0;
    end
  endtask

  task automatic send_one(input int src, input int d);
    int dv[NP];
    for (int i = 0; i < NP; i++) dv[i] = d;
    send_multi(NP'(1) << src, dv);
  endtask

  task automatic wait_drain(input int lim);
    int n = 0;
    while (rx_total != tx_total && n < lim) begin
      @(posedge clk);
      n++;
    end
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == '0, "R1 out_valid low in reset", out_valid, 0);
    check(in_ready == '1, "R1 in_ready high in reset", in_ready, 8'hFF);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    in_sop = '1;
    #1;
    check(in_ready == '1 && out_valid == '0, "R1 state after reset release",
          {in_ready, out_valid}, 16'hFF00);
    in_sop = '0;
  endtask

  task automatic t_single;
    int base;
    out_ready = '1;
    base = rx_cnt[5];
    send_one(0, 5);
    wait_drain(200);
    check(rx_cnt[5] == base + 1, "R2 single cell reaches output 5", rx_cnt[5], base + 1);
    check(rx_total == tx_total, "R2 no cell elsewhere or lost", rx_total, tx_total);
  endtask

  task automatic t_perm;
    int dv[NP];
    int base[NP];
    int t0;
    for (int o = 0; o < NP; o++) base[o] = rx_cnt[o];
    t0 = cyc;
    for (int s = 0; s < NP; s++) begin
      for (int i = 0; i < NP; i++) dv[i] = (i + s) % NP;
      send_multi('1, dv);
    end
    wait_drain(400);
    check(cyc - t0 <= 100, "R8 conflict-free traffic moves in parallel", cyc - t0, 100);
    for (int o = 0; o < NP; o++)
      check(rx_cnt[o] == base[o] + NP, "R8 every output served once per batch",
            rx_cnt[o], base[o] + NP);
  endtask

  task automatic t_framing;
    int base;
    bit rdy = 1;
    base = rx_cnt[4];
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid[2] = 1'b1;
      in_sop[2]   = 1'b0;
      in_data[2*W +: W] = 16'h0004;
      #1;
      if (!in_ready[2]) rdy = 0;
    end
    @(posedge clk);
    #1;
    in_valid[2] = 1'b0;
    check(rdy, "R3 stray beats are accepted", rdy, 1);
    send_one(2, 4);
    wait_drain(200);
    repeat (30) @(posedge clk);
    #1;
    check(rx_cnt[4] == base + 1, "R3 stray beats make no cell", rx_cnt[4], base + 1);
  endtask

  task automatic t_rr;
    int dv[NP];
    int b0;
    int exp1[4] = '{4, 0, 1, 2};
    for (int i = 0; i < NP; i++) dv[i] = 0;
    send_one(2, 0);
    wait_drain(200);
    b0 = ord_n;
    send_multi(8'b0001_0111, dv);
    wait_drain(300);
    for (int k = 0; k < 4; k++)
      check(ord_log[b0 + k] == exp1[k], "R7 rotation after grant to input 2",
            ord_log[b0 + k], exp1[k]);
    b0 = ord_n;
    send_multi('1, dv);
    wait_drain(400);
    for (int k = 0; k < NP; k++)
      check(ord_log[b0 + k] == (3 + k) % NP, "R7 full contention order",
            ord_log[b0 + k], (3 + k) % NP);
  endtask

  task automatic t_backpressure;
    int b6, b2, sq, n;
    bit blocked = 1, held = 1;
    out_ready = '1;
    out_ready[6] = 1'b0;
    b6 = rx_cnt[6];
    b2 = rx_cnt[2];
    sq = exp_seq[1][6];
    n = tx_total;
    for (int c = 0; c < 40; c++) send_one(1, 6);
    check(tx_total - n == 40, "R4 40 cells buffered toward a stalled output", tx_total - n, 40);
    repeat (30) @(posedge clk);
    @(negedge clk);
    in_valid[1] = 1'b1;
    in_sop[1]   = 1'b1;
    in_data[1*W +: W] = cell_word(1, 6, tx_seq[1][6], 0);
    for (int k = 0; k < 12; k++) begin
      #1;
      if (in_ready[1]) blocked = 0;
      if (!out_valid[6] || !out_sop[6] || out_data[6*W +: W] != cell_word(1, 6, sq, 0)) held = 0;
      @(negedge clk);
    end
    check(blocked, "R4 first beat refused when queue holds 8", !blocked, 0);
    check(held, "R9 stalled output holds its beat", held, 1);
    check(rx_cnt[6] == b6, "R6 nothing leaves a stalled output", rx_cnt[6], b6);
    in_valid[1] = 1'b0;
    in_sop[1]   = 1'b0;
    send_one(1, 2);
    n = 0;
    while (rx_cnt[2] == b2 && n < 200) begin @(posedge clk); n++; end
    #1;
    check(rx_cnt[2] == b2 + 1, "R5 other destination still flows", rx_cnt[2], b2 + 1);
    @(posedge clk);
    #1;
    out_ready[6] = 1'b1;
    send_one(1, 6);
    wait_drain(1000);
    check(rx_cnt[6] == b6 + 41, "R6 all held cells delivered after drain", rx_cnt[6], b6 + 41);
  endtask

  task automatic t_stall;
    int dv[NP];
    stall_on = 1;
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < NP; i++) dv[i] = int'((lfsr_t >> (i * 2)) & 16'h7);
      lfsr_t = {lfsr_t[14:0], lfsr_t[15] ^ lfsr_t[13] ^ lfsr_t[12] ^ lfsr_t[10]};
      send_multi('1, dv);
    end
    @(posedge clk);
    stall_on = 0;
    #2;
    out_ready = '1;
    wait_drain(3000);
    check(rx_total == tx_total, "R9 random egress stalls lose no cell", rx_total, tx_total);
    check(tx_total > 0, "R10 traffic was generated", tx_total, 1);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      rx_cnt[i] = 0;
      rx_beat[i] = 0;
      rx_bad[i] = 0;
      for (int d = 0; d < NP; d++) begin tx_seq[i][d] = 0; exp_seq[i][d] = 0; end
    end
    t_reset();
    t_single();
    t_perm();
    t_framing();
    t_rr();
    t_backpressure();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule